// File: doc/BRIEF.md
# ADC Ramp Test-Pattern Checker

This block checks ADC sample data while the converter is driven into a free-running ramp test mode. Each channel (I and Q) has its own checker. Once armed, a checker searches the incoming samples for the code zero. The first zero it sees locks it to the ramp. From then on it expects every following sample to be one greater than the sample before it. Each sample that does not match adds one to a saturating error counter.

The arm control is a single enable level, normally driven by a configuration register. A rising edge on that enable clears both channels and restarts the search for zero. While the enable is low, the lock flags and error counts hold their values so that they can be read. Software decides pass or fail from two separate signs:
- a channel that never locked;
- a nonzero error count.

Top module: `adc_rampchk`

## Requirements
- R1: After arming, a channel's locked output stays 0 until that channel receives a valid sample equal to code 0. The locked output reads 1 on the clock edge after that sample.
- R2: The sample after the locking zero is expected to be 1. While locked, each valid sample that differs from the expected value adds exactly one to that channel's error count.
- R3: After every valid sample taken while locked, the expected value becomes that sample plus one, whether it matched or not. A step jump in the ramp therefore adds one error, and an isolated spike adds two errors.
- R4: The expected value wraps from code 2^SAMPLE_W-1 (16383 at the default 14 bits) back to 0, and this wrap is not an error.
- R5: Samples presented with valid_i low are ignored. They change neither the lock, the count, nor the expected value.
- R6: A rising edge of enable_i clears the lock flag and the error count of both channels on the next edge. The sample in the cycle of that rising edge is ignored, even if it is 0, and the search for zero restarts.
- R7: While enable_i is low, the lock flags and error counts hold their values and all samples are ignored.
- R8: Channel 0 (I) and channel 1 (Q) are independent. Samples on one channel never change the lock or the count of the other.
- R9: The error count is CNT_W bits wide (32 by default). It saturates at 2^CNT_W-1 and does not wrap.
- R10: After reset, both locked outputs are 0 and both error counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Arm level; a rising edge rearms both channels |
| valid_i | input | 1 | Sample strobe for both channels |
| sample_i | input | N_CH x SAMPLE_W | Samples; index 0 is I, index 1 is Q |
| locked_o | output | N_CH | Per-channel lock flag |
| err_cnt_o | output | N_CH x CNT_W | Per-channel saturating error count |

## Verification
The checker is driven through several input patterns:
- A ramp without zeros shows that lock waits for code 0.
- A clean ramp shows that matches add no errors.
- A step jump shows that the expectation resynchronises, costing one error rather than a cascade.
- An isolated spike costs exactly two errors.
- A ramp across the top code shows that the wrap is accepted.

Strobe-low garbage, disabled-time garbage and a zero presented in the rearm cycle show that each of these is ignored, because a following in-ramp sample would otherwise be miscounted. A run of constant values on a narrow-counter instance shows saturation, while the default-width instance counts past that value under the same stimulus.

// File: rtl/adc_rampchk_pkg.sv
package adc_rampchk_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_TRACK  = 1'b1
  } lane_st_e;
endpackage

// File: rtl/adc_rampchk_arm.sv
module adc_rampchk_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  output logic clr_o,
  output logic run_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  assign clr_o = enable_i & ~en_q;
  assign run_o = enable_i & en_q;

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o); // R6
endmodule

// File: rtl/adc_rampchk_lane.sv
module adc_rampchk_lane
  import adc_rampchk_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                run_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                locked_o,
  output logic                err_inc_o
);
  lane_st_e            st_q;
  logic [SAMPLE_W-1:0] exp_q;
  logic                take;

  assign take      = run_i & valid_i;
  assign locked_o  = (st_q == ST_TRACK);
  assign err_inc_o = take & (st_q == ST_TRACK) & (sample_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SEARCH;
      exp_q <= '0;
    end else if (clr_i) begin
      st_q  <= ST_SEARCH;
      exp_q <= '0;
    end else if (take) begin
      // resync on every sample; wraps naturally at SAMPLE_W
      exp_q <= sample_i + SAMPLE_W'(1);
      if (st_q == ST_SEARCH && sample_i == '0) st_q <= ST_TRACK;
    end
  end

  AST_LOCK_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(run_i && valid_i && sample_i == '0)); // R1
  AST_UNLOCK_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !locked_o); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> ($stable(exp_q) && $stable(st_q))); // R5
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(locked_o)); // R7
endmodule

// File: rtl/adc_rampchk_cnt.sv
module adc_rampchk_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (inc_i && cnt_o != CntMax) cnt_o <= cnt_o + CNT_W'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CntMax && !clr_i) |=> cnt_o == CntMax); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1))); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0); // R6
endmodule

// File: rtl/adc_rampchk.sv
module adc_rampchk #(
  parameter int N_CH     = 2,
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic                          valid_i,
  input  logic [N_CH-1:0][SAMPLE_W-1:0] sample_i,
  output logic [N_CH-1:0]               locked_o,
  output logic [N_CH-1:0][CNT_W-1:0]    err_cnt_o
);
  logic clr, run;

  adc_rampchk_arm u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .clr_o    (clr),
    .run_o    (run)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic err_inc;

    adc_rampchk_lane #(.SAMPLE_W(SAMPLE_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .run_i     (run),
      .valid_i   (valid_i),
      .sample_i  (sample_i[ch]),
      .locked_o  (locked_o[ch]),
      .err_inc_o (err_inc)
    );

    adc_rampchk_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .inc_i  (err_inc),
      .cnt_o  (err_cnt_o[ch])
    );

    AST_COUNT_FROZEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> $stable(err_cnt_o[ch])); // R7
  end
endmodule

// File: tb/adc_rampchk_test.sv
module adc_rampchk_test;
  localparam int SW = 14;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic               vld = 1'b0;
  logic [1:0][SW-1:0] smp = '0;
  logic [1:0]         locked, locked_s;
  logic [1:0][31:0]   cnt;
  logic [1:0][3:0]    cnt_s;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  adc_rampchk uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .valid_i(vld),
    .sample_i(smp), .locked_o(locked), .err_cnt_o(cnt)
  );

  adc_rampchk #(.CNT_W(4)) uut_sat (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .valid_i(vld),
    .sample_i(smp), .locked_o(locked_s), .err_cnt_o(cnt_s)
  );

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive(int si, int sq, bit v = 1'b1);
    @(negedge clk);
    vld    = v;
    smp[0] = SW'(si);
    smp[1] = SW'(sq);
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 locked I", locked[0], 0);
    chk("R10 locked Q", locked[1], 0);
    chk("R10 count I", cnt[0], 0);
    chk("R10 count Q", cnt[1], 0);
  endtask

  task automatic t_lock();
    @(negedge clk); en = 1'b1; vld = 1'b0;
    drive(5, 200); drive(6, 201); drive(7, 202); idle();
    chk("R1 no lock without zero", locked[0], 0);
    drive(0, 203); drive(1, 204); drive(2, 205); drive(3, 206); idle();
    chk("R1 lock after zero", locked[0], 1);
    chk("R2 clean ramp no errors", cnt[0], 0);
    chk("R8 Q still unlocked", locked[1], 0);
    chk("R8 Q count untouched", cnt[1], 0);
  endtask

  task automatic t_jump();
    drive(4, 300); drive(9, 300); drive(10, 300); drive(11, 300); idle();
    chk("R3 step counts once", cnt[0], 1);
    drive(12, 300); drive(40, 300); drive(14, 300); idle();
    chk("R2 spike counts two", cnt[0], 3);
  endtask

  task automatic t_wrap();
    drive(16382, 300); drive(16383, 300); drive(0, 300); drive(1, 300); drive(2, 300); idle();
    chk("R4 wrap accepted", cnt[0], 4);
    chk("R4 still locked", locked[0], 1);
  endtask

  task automatic t_valid();
    drive(777, 777, 1'b0); drive(778, 778, 1'b0); drive(779, 779, 1'b0);
    drive(3, 300); idle();
    chk("R5 strobe-low ignored", cnt[0], 4);
  endtask

  task automatic t_q();
    drive(4, 0); drive(5, 1); drive(6, 2); drive(7, 50); drive(8, 51); idle();
    chk("R8 Q locked", locked[1], 1);
    chk("R8 Q count", cnt[1], 1);
    chk("R8 I count unaffected", cnt[0], 4);
  endtask

  task automatic t_freeze();
    @(negedge clk); en = 1'b0; vld = 1'b0;
    drive(1000, 1000); drive(2000, 2000); drive(0, 0); idle();
    chk("R7 I lock held", locked[0], 1);
    chk("R7 Q lock held", locked[1], 1);
    chk("R7 I count held", cnt[0], 4);
    chk("R7 Q count held", cnt[1], 1);
  endtask

  task automatic t_rearm();
    @(negedge clk); en = 1'b1; vld = 1'b1; smp = '0;
    idle();
    chk("R6 I unlocked", locked[0], 0);
    chk("R6 Q unlocked", locked[1], 0);
    chk("R6 I cleared", cnt[0], 0);
    chk("R6 Q cleared", cnt[1], 0);
    drive(3, 3); idle();
    chk("R6 search restarted", locked[0], 0);
    drive(0, 0); idle();
    chk("R6 relock", locked[0], 1);
  endtask

  task automatic t_sat();
    for (int k = 0; k < 20; k++) drive(100, 100);
    idle();
    chk("R9 narrow count saturates", cnt_s[0], 15);
    chk("R9 narrow Q saturates", cnt_s[1], 15);
    chk("R9 wide count continues", cnt[0], 20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_jump();
    t_wrap();
    t_valid();
    t_q();
    t_freeze();
    t_rearm();
    t_sat();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule